// File: doc/BRIEF.md
# Timed Sequencer with Signal Wait and Event Handshake

This block holds a four-state sequencer and a companion trigger generator. Both are clocked at 100 MHz and each state machine has its own reloading delay timer. The sequencer starts in `M_IDLE` (integer 0). After 3.5 µs it moves to `M_DRIVE` (1), which raises output pin 0 for 1 µs. It then moves to `M_WAIT` (2), which drops the pin and holds until the trigger is seen high. Next comes `M_HOLD` (3), which lasts 2 µs, and after that the sequence restarts at `M_IDLE`.

The generator drives the trigger. It stays in `G_LOW` (0, trigger low) for 10 µs and then enters `G_HIGH` (1, trigger high). In timed mode `G_HIGH` ends after another 10 µs. In event mode `G_HIGH` raises an event request, which stays up until a one-cycle acknowledge arrives, and only then does the generator return to `G_LOW`.

An external counter rollover input can push the sequencer one step forward. If a timed expiry falls on the same cycle, the rollover adds no further step.

Top module: `timed_sequencer`

## Requirements
- R1: While reset is active and immediately after it, `main_state` is 0, `gen_state` is 0, and `pin0`, `trigger` and `ev_req` are all low.
- R2: The sequencer spends exactly 350 clock cycles in state 0 (`M_IDLE`, transition IDLE→DRIVE) and then moves to state 1.
- R3: `pin0` is high exactly while `main_state` is 1 (`M_DRIVE`). State 1 lasts 100 cycles and then moves to state 2 (DRIVE→WAIT).
- R4: In state 2 (`M_WAIT`) `pin0` is low. The state moves to 3 on the first clock edge at which `trigger` is sampled high (WAIT→HOLD).
- R5: State 3 (`M_HOLD`) lasts 200 cycles and then returns to state 0 (HOLD→IDLE). The `main_state` value only ever moves 0→1→2→3→0.
- R6: With `event_mode` low, the generator holds `trigger` low for 1000 cycles and then high for 1000 cycles, and repeats. `gen_state` is 1 exactly when `trigger` is high.
- R7: With `event_mode` high, `ev_req` is high exactly while the generator is in state 1. The generator leaves state 1 on the edge at which `ev_ack` is sampled high, and never leaves it on time alone.
- R8: An `ev_ack` pulse while the generator is in state 0 has no effect.
- R9: A high `ext_roll`, sampled in any sequencer state, advances the sequencer one step. The delay of the new state starts from its full length.
- R10: If `ext_roll` is sampled high on the same edge as a timed expiry, the sequencer advances exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_mode | input | 1 | 1: generator leaves its high state on acknowledge; 0: on time |
| ev_ack | input | 1 | Single-cycle event acknowledge |
| ext_roll | input | 1 | External counter rollover, forces one sequencer step |
| pin0 | output | 1 | Output pin 0, high in state 1 |
| trigger | output | 1 | Trigger from the generator, also watched by the sequencer |
| ev_req | output | 1 | Event 0 request, held until acknowledged |
| main_state | output | 2 | Sequencer state integer 0..3 |
| gen_state | output | 1 | Generator state integer 0..1 |

## Verification
A wrong sequencer state shows at the ports at once, because `main_state` and `pin0` change on the same edge as the state register. A timer that is miscounted or that does not reload on entry shows as a transition at the wrong absolute cycle, and every later transition then moves by the same amount. A bad trigger wait or a bad handshake makes a `M_WAIT` exit land at the wrong point relative to the `trigger` edge, or keeps `ev_req` high for the wrong span. A rollover that adds a step skips a state integer, which shows within one cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_DRIVE = 2'd1,
        M_WAIT  = 2'd2,
        M_HOLD  = 2'd3
    } main_st_t;

    typedef enum logic {
        G_LOW  = 1'b0,
        G_HIGH = 1'b1
    } gen_st_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W       = 10,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R2
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/seq_main_fsm.sv
module seq_main_fsm
    import seq_pkg::*;
#(
    parameter int CYC_INIT = 350,
    parameter int CYC_HIGH = 100,
    parameter int CYC_DONE = 200
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     trig,
    input  logic     ext_roll,
    output main_st_t state,
    output logic     pin0
);
    localparam int MAXC = (CYC_INIT > CYC_HIGH) ?
                          ((CYC_INIT > CYC_DONE) ? CYC_INIT : CYC_DONE) :
                          ((CYC_HIGH > CYC_DONE) ? CYC_HIGH : CYC_DONE);
    localparam int W = $clog2(MAXC + 1);
    localparam logic [W-1:0] L_INIT = W'(CYC_INIT - 1);
    localparam logic [W-1:0] L_HIGH = W'(CYC_HIGH - 1);
    localparam logic [W-1:0] L_DONE = W'(CYC_DONE - 1);

    main_st_t     nxt;
    logic         tmr_zero;
    logic         load;
    logic [W-1:0] load_val;

    seq_timer #(.W(W), .RST_VAL(CYC_INIT - 1)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .zero     (tmr_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= M_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE:  if (tmr_zero || ext_roll) nxt = M_DRIVE;
            M_DRIVE: if (tmr_zero || ext_roll) nxt = M_WAIT;
            M_WAIT:  if (trig || ext_roll)     nxt = M_HOLD;
            M_HOLD:  if (tmr_zero || ext_roll) nxt = M_IDLE;
        endcase
    end

    always_comb begin
        load     = (nxt != state);
        load_val = '0;
        unique case (nxt)
            M_IDLE:  load_val = L_INIT;
            M_DRIVE: load_val = L_HIGH;
            M_WAIT:  load_val = '0;
            M_HOLD:  load_val = L_DONE;
        endcase
        pin0 = (state == M_DRIVE);
    end

    // R5
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> (state == main_st_t'($past(state) + 2'd1)));

    // R9
    timed_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state) && $past(state) != M_WAIT) |->
            ($past(tmr_zero) || $past(ext_roll)));

    // R4
    wait_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_WAIT && trig) |=> (state == M_HOLD));
endmodule

// File: rtl/seq_trig_gen.sv
module seq_trig_gen
    import seq_pkg::*;
#(
    parameter int CYC_TOGGLE = 1000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    event_mode,
    input  logic    ev_ack,
    output gen_st_t state,
    output logic    trigger,
    output logic    ev_req
);
    localparam int W = $clog2(CYC_TOGGLE + 1);
    localparam logic [W-1:0] L_TOG = W'(CYC_TOGGLE - 1);

    gen_st_t nxt;
    logic    tmr_zero;
    logic    load;

    seq_timer #(.W(W), .RST_VAL(CYC_TOGGLE - 1)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (L_TOG),
        .zero     (tmr_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= G_LOW;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            G_LOW:  if (tmr_zero) nxt = G_HIGH;
            G_HIGH: if (event_mode ? ev_ack : tmr_zero) nxt = G_LOW;
        endcase
        load = (nxt != state);
    end

    always_comb begin
        trigger = (state == G_HIGH);
        ev_req  = (state == G_HIGH) && event_mode;
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_req && !ev_ack && event_mode) |=> trigger);

    // R8
    ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_LOW && !tmr_zero && ev_ack) |=> !trigger);
endmodule

// File: rtl/timed_sequencer.sv
module timed_sequencer #(
    parameter int CYC_INIT   = 350,
    parameter int CYC_HIGH   = 100,
    parameter int CYC_DONE   = 200,
    parameter int CYC_TOGGLE = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       event_mode,
    input  logic       ev_ack,
    input  logic       ext_roll,
    output logic       pin0,
    output logic       trigger,
    output logic       ev_req,
    output logic [1:0] main_state,
    output logic       gen_state
);
    import seq_pkg::*;

    main_st_t m_st;
    gen_st_t  g_st;
    logic     trig_w;

    seq_trig_gen #(.CYC_TOGGLE(CYC_TOGGLE)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_mode (event_mode),
        .ev_ack     (ev_ack),
        .state      (g_st),
        .trigger    (trig_w),
        .ev_req     (ev_req)
    );

    seq_main_fsm #(
        .CYC_INIT (CYC_INIT),
        .CYC_HIGH (CYC_HIGH),
        .CYC_DONE (CYC_DONE)
    ) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig_w),
        .ext_roll (ext_roll),
        .state    (m_st),
        .pin0     (pin0)
    );

    assign trigger    = trig_w;
    assign main_state = m_st;
    assign gen_state  = g_st;

    // R3
    pin_low_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_state == 2'd2) |-> !pin0);
endmodule

// File: tb/tb_timed_sequencer.sv
module tb_timed_sequencer;
    typedef struct {
        int cyc;
        int val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       event_mode = 1'b0;
    logic       ev_ack = 1'b0;
    logic       ext_roll = 1'b0;
    logic       pin0, trigger, ev_req, gen_state;
    logic [1:0] main_state;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    exp_t mq[$];
    exp_t gq[$];
    logic [1:0] pm = 2'd0;
    logic       pg = 1'b0;

    always #5 clk = ~clk;

    timed_sequencer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_mode (event_mode),
        .ev_ack     (ev_ack),
        .ext_roll   (ext_roll),
        .pin0       (pin0),
        .trigger    (trigger),
        .ev_req     (ev_req),
        .main_state (main_state),
        .gen_state  (gen_state)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic exp_main(input int c, input int v, input string tag);
        exp_t e;
        e.cyc = c; e.val = v; e.tag = tag;
        mq.push_back(e);
    endtask

    task automatic exp_gen(input int c, input int v, input string tag);
        exp_t e;
        e.cyc = c; e.val = v; e.tag = tag;
        gq.push_back(e);
    endtask

    // monitor: compares every observed state change with the scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            pm = main_state;
            pg = trigger;
        end else begin
            if (main_state != pm) begin
                if (mq.size() == 0) begin
                    check(1'b0, "R5 unexpected main change", int'(main_state), int'(pm));
                end else begin
                    exp_t e;
                    e = mq.pop_front();
                    check(main_state == 2'(e.val), {e.tag, " state"}, int'(main_state), e.val);
                    check(cyc == e.cyc, {e.tag, " cycle"}, cyc, e.cyc);
                end
                check(pin0 == (main_state == 2'd1), "R3 pin0", int'(pin0), int'(main_state == 2'd1));
                pm = main_state;
            end
            if (trigger != pg) begin
                if (gq.size() == 0) begin
                    check(1'b0, "R6 unexpected trigger change", int'(trigger), int'(pg));
                end else begin
                    exp_t e;
                    e = gq.pop_front();
                    check(trigger == e.val[0], {e.tag, " trigger"}, int'(trigger), e.val);
                    check(cyc == e.cyc, {e.tag, " cycle"}, cyc, e.cyc);
                end
                check(gen_state == trigger, "R6 gen_state", int'(gen_state), int'(trigger));
                pg = trigger;
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        ext_roll = 1'b0;
        ev_ack = 1'b0;
        mq.delete();
        gq.delete();
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(main_state == 2'd0 && gen_state == 1'b0, "R1 states in reset",
              int'({main_state, gen_state}), 0);
        check(!pin0 && !trigger && !ev_req, "R1 outputs in reset",
              int'({pin0, trigger, ev_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(main_state == 2'd0 && !pin0 && !trigger && !ev_req, "R1 after reset",
              int'({main_state, pin0, trigger, ev_req}), 0);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // pulse a one-cycle input so it is sampled on edge number e
    task automatic pulse_roll(input int e);
        wait_until(e - 1);
        ext_roll = 1'b1;
        @(negedge clk);
        ext_roll = 1'b0;
    endtask

    task automatic pulse_ack(input int e);
        wait_until(e - 1);
        ev_ack = 1'b1;
        @(negedge clk);
        ev_ack = 1'b0;
    endtask

    task automatic drain(input string tag);
        check(mq.size() == 0, {tag, " main queue empty"}, mq.size(), 0);
        check(gq.size() == 0, {tag, " gen queue empty"}, gq.size(), 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // scenario 1: timed generator, no rollover
        event_mode = 1'b0;
        do_reset();
        exp_main(350, 1, "R2");
        exp_main(450, 2, "R3");
        exp_main(1001, 3, "R4");
        exp_main(1201, 0, "R5");
        exp_main(1551, 1, "R2");
        exp_main(1651, 2, "R3");
        exp_main(1652, 3, "R4");
        exp_main(1852, 0, "R5");
        exp_main(2202, 1, "R2");
        exp_main(2302, 2, "R3");
        exp_main(3001, 3, "R4");
        exp_main(3201, 0, "R5");
        exp_gen(1000, 1, "R6");
        exp_gen(2000, 0, "R6");
        exp_gen(3000, 1, "R6");
        wait_until(1500);
        check(!ev_req, "R6 no request in timed mode", int'(ev_req), 0);
        wait_until(3300);
        drain("R6 scenario");

        // scenario 2: event handshake
        event_mode = 1'b1;
        do_reset();
        exp_main(350, 1, "R2");
        exp_main(450, 2, "R3");
        exp_main(1001, 3, "R4");
        exp_main(1201, 0, "R5");
        exp_main(1551, 1, "R2");
        exp_main(1651, 2, "R3");
        exp_main(1652, 3, "R4");
        exp_main(1852, 0, "R5");
        exp_main(2202, 1, "R2");
        exp_main(2302, 2, "R3");
        exp_main(2303, 3, "R7");
        exp_main(2503, 0, "R5");
        exp_main(2853, 1, "R2");
        exp_main(2953, 2, "R3");
        exp_main(3501, 3, "R4");
        exp_gen(1000, 1, "R6");
        exp_gen(2500, 0, "R7");
        exp_gen(3500, 1, "R6");
        pulse_ack(500);
        wait_until(600);
        check(!trigger && gen_state == 1'b0, "R8 ack ignored in low",
              int'({trigger, gen_state}), 0);
        check(!ev_req, "R8 no request in low", int'(ev_req), 0);
        wait_until(1500);
        check(ev_req, "R7 request while high", int'(ev_req), 1);
        wait_until(2100);
        check(trigger && ev_req, "R7 high held past timed limit",
              int'({trigger, ev_req}), 3);
        pulse_ack(2500);
        check(!ev_req && !trigger, "R7 request dropped on ack",
              int'({ev_req, trigger}), 0);
        wait_until(3600);
        drain("R7 scenario");

        // scenario 3: external rollover
        event_mode = 1'b0;
        do_reset();
        exp_main(100, 1, "R9");
        exp_main(200, 2, "R9");
        exp_main(300, 3, "R9");
        exp_main(500, 0, "R9");
        exp_main(850, 1, "R2");
        exp_main(950, 2, "R10");
        exp_main(1001, 3, "R4");
        exp_main(1201, 0, "R5");
        exp_main(1551, 1, "R10");
        exp_main(1651, 2, "R3");
        exp_main(1652, 3, "R4");
        exp_gen(1000, 1, "R6");
        pulse_roll(100);
        pulse_roll(300);
        pulse_roll(950);
        pulse_roll(1551);
        wait_until(1700);
        drain("R10 scenario");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule